// File: doc/BRIEF.md
# Keyboard Port Event Flag Register

This block holds one sticky event flag for each line of an 8-bit input port, as used by a keyboard-style wake-up and interrupt interface. Each line has a programmable active level and an enable bit. While an enabled line sits at its active level, the hardware sets that line's flag on every clock edge. Software can only clear flags, by writing zero to them through a small register-access port. That port carries a read strobe, a write strobe, and a qualifier that marks an access as one half of a read-modify-write cycle.

The block keeps track of the window that opens at a qualified read of the flag register and closes at the next write. Any line whose event shows up inside that window is protected from the write-back. The write-back carries the value that was read earlier, so without this protection it would wipe out an event that software never saw. Bit-test-and-clear style accesses are issued as read-modify-write cycles and follow the same rule. The combined interrupt request is the registered OR of all enabled flags.

Top module: `kbd_evt_flags`

## Requirements
- R1: While reset is high, the flag, level and enable registers all clear to zero and irq clears to 0.
- R2: Register select encoding is 0 for flags, 1 for level, 2 for enable and 3 unused. bus_rdata always shows the selected register without delay. Writes to level or enable take effect at the write edge.
- R3: A line whose enable bit is 1 and whose input equals its level bit (1 means active high, 0 means active low) sets its flag at the next clock edge. An input held for a single cycle is captured.
- R4: A line whose enable bit is 0 never sets its flag, whatever its input does.
- R5: A plain write to the flag register clears every flag whose data bit is 0. Data bits of 1 leave their flags unchanged, and software can never set a flag.
- R6: A read with bus_rmw high to the flag register opens a window. A write with bus_rmw high closes it and clears only those flags whose event was absent from the read cycle through the write cycle.
- R7: A flag whose event came before the qualified read is cleared by the read-modify-write write-back of zero.
- R8: An event on a line in the same cycle as a write that would clear that line's flag wins, and the flag stays set.
- R9: irq equals the OR of flags ANDed with enables, delayed by one register, so it rises one cycle after a flag sets and falls one cycle after the last enabled flag goes away.
- R10: irq stays asserted for as long as an enabled input is held at its active level, even when software keeps clearing the flags.
- R11: Select code 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | 8 | Monitored port lines |
| bus_sel | input | 2 | Register select (0 flags, 1 level, 2 enable, 3 unused) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rmw | input | 1 | Marks the access as one half of a read-modify-write cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Registered combined interrupt request |

## Verification
Hardware setting and software clearing can hit the same flag in the same cycle, so this is the collision the bench concentrates on. The first case is an input pulse that lands exactly in the qualified read cycle, or in the cycles between that read and its write-back. There the write-back of zero must leave the flag set, while a flag set before the read is cleared. The second case is an input held at its active level in the very cycle of a clearing plain write. There the flag, as read back, must still be set, and irq must stay high.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

    localparam int unsigned LINES  = 8;
    localparam int unsigned SEL_W  = 2;

    typedef logic [LINES-1:0] line_vec_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_LEVEL  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      rd;
        logic      wr;
        logic      rmw;
        reg_sel_e  sel;
        line_vec_t wdata;
    } bus_req_t;

    // a line is active when enabled and its pin equals its level bit
    function automatic logic line_active(logic pin, logic lvl, logic en);
        return en & ~(pin ^ lvl);
    endfunction

endpackage

// File: rtl/kbd_evt_detect.sv
module kbd_evt_detect
    import kbd_evt_pkg::*;
(
    input  line_vec_t pins,
    input  line_vec_t lvl,
    input  line_vec_t en,
    output line_vec_t evt
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign evt[i] = line_active(pins[i], lvl[i], en[i]);
    end
endmodule

// File: rtl/kbd_evt_rmw_track.sv
module kbd_evt_rmw_track
    import kbd_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    input  line_vec_t evt,
    output line_vec_t protect
);
    logic      win_q;
    line_vec_t late_q;
    logic      open_rd;
    logic      close_wr;

    assign open_rd  = req.rd && req.rmw && (req.sel == SEL_FLAGS);
    assign close_wr = req.wr && req.rmw && (req.sel == SEL_FLAGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= 1'b0;
            late_q <= '0;
        end else if (open_rd) begin
            // the read samples the old value, so an event in this cycle is late
            win_q  <= 1'b1;
            late_q <= evt;
        end else if (req.wr) begin
            win_q  <= 1'b0;
            late_q <= '0;
        end else if (win_q) begin
            late_q <= late_q | evt;
        end
    end

    assign protect = (win_q && close_wr) ? late_q : '0;
endmodule

// File: rtl/kbd_evt_flag_bank.sv
module kbd_evt_flag_bank
    import kbd_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t evt,
    input  logic      clr_en,
    input  line_vec_t wdata,
    input  line_vec_t protect,
    output line_vec_t flags
);
    line_vec_t flags_q;

    for (genvar i = 0; i < LINES; i++) begin : g_bit
        logic keep;
        assign keep = ~clr_en | wdata[i] | protect[i];
        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= (flags_q[i] & keep) | evt[i];
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/kbd_evt_cfg.sv
module kbd_evt_cfg
    import kbd_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    input  line_vec_t flags,
    output line_vec_t lvl,
    output line_vec_t en,
    output line_vec_t rdata
);
    line_vec_t lvl_q;
    line_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            en_q  <= '0;
        end else if (req.wr) begin
            if (req.sel == SEL_LEVEL)  lvl_q <= req.wdata;
            if (req.sel == SEL_ENABLE) en_q  <= req.wdata;
        end
    end

    always_comb begin
        unique case (req.sel)
            SEL_FLAGS:  rdata = flags;
            SEL_LEVEL:  rdata = lvl_q;
            SEL_ENABLE: rdata = en_q;
            default:    rdata = '0;
        endcase
    end

    assign lvl = lvl_q;
    assign en  = en_q;
endmodule

// File: rtl/kbd_evt_flags.sv
module kbd_evt_flags
    import kbd_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] port_in,
    input  logic [1:0] bus_sel,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic       bus_rmw,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    bus_req_t  req;
    line_vec_t lvl_q;
    line_vec_t en_q;
    line_vec_t flags_q;
    line_vec_t evt;
    line_vec_t protect;
    logic      flag_wr;
    logic      irq_q;

    assign req.rd    = bus_rd;
    assign req.wr    = bus_wr;
    assign req.rmw   = bus_rmw;
    assign req.sel   = reg_sel_e'(bus_sel);
    assign req.wdata = bus_wdata;

    assign flag_wr = bus_wr && (req.sel == SEL_FLAGS);

    kbd_evt_detect u_detect (
        .pins (port_in),
        .lvl  (lvl_q),
        .en   (en_q),
        .evt  (evt)
    );

    kbd_evt_rmw_track u_track (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .evt     (evt),
        .protect (protect)
    );

    kbd_evt_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr_en  (flag_wr),
        .wdata   (bus_wdata),
        .protect (protect),
        .flags   (flags_q)
    );

    kbd_evt_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .flags (flags_q),
        .lvl   (lvl_q),
        .en    (en_q),
        .rdata (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags_q & en_q);
    end

    assign irq = irq_q;
endmodule

// File: rtl/kbd_evt_flags_chk.sv
module kbd_evt_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] port_in,
    input logic [1:0] bus_sel,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic [7:0] flags_q,
    input logic [7:0] lvl_q,
    input logic [7:0] en_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flags_q == 8'h00 && lvl_q == 8'h00 && en_q == 8'h00 && !irq));

    for (genvar i = 0; i < 8; i++) begin : g_line
        a_r3_level_sets: assert property (@(posedge clk) disable iff (rst)
            (en_q[i] && (port_in[i] == lvl_q[i])) |=> flags_q[i]);

        a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            (!en_q[i] && !flags_q[i]) |=> !flags_q[i]);

        a_r5_no_sw_set: assert property (@(posedge clk) disable iff (rst)
            (!flags_q[i] && !(en_q[i] && (port_in[i] == lvl_q[i]))) |=> !flags_q[i]);

        a_r5_one_keeps: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_sel == 2'd0 && bus_wdata[i] && flags_q[i]) |=> flags_q[i]);
    end

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
        (|(flags_q & en_q)) |=> irq);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(flags_q & en_q)));

    a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd3) |-> (bus_rdata == 8'h00));
endmodule

bind kbd_evt_flags kbd_evt_flags_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .port_in   (port_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .flags_q   (flags_q),
    .lvl_q     (lvl_q),
    .en_q      (en_q)
);

// File: tb/kbd_evt_flags_tb.sv
`timescale 1ns/1ps
module kbd_evt_flags_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_in = 8'hFF;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rmw = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    kbd_evt_flags u_dut (
        .clk       (clk),
        .rst       (rst),
        .port_in   (port_in),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rmw   (bus_rmw),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // level, enable, pattern, expected flags
    localparam logic [31:0] VECS [5] = '{
        {8'h00, 8'hFF, 8'hF0, 8'h0F},
        {8'hFF, 8'hFF, 8'hA5, 8'hA5},
        {8'h0F, 8'h3C, 8'h33, 8'h00},
        {8'h55, 8'hF0, 8'h5A, 8'hF0},
        {8'h00, 8'h81, 8'h7E, 8'h81}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(logic [1:0] sel, logic [7:0] d, logic rmw);
        bus_sel = sel; bus_wdata = d; bus_rmw = rmw; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic rmw_read();
        bus_sel = 2'd0; bus_rd = 1'b1; bus_rmw = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] sel, logic [7:0] exp);
        bus_sel = sel;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        idle(4);
        rd_check("R1 flags", 2'd0, 8'h00);
        rd_check("R1 level", 2'd1, 8'h00);
        rd_check("R1 enable", 2'd2, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rst = 1'b0;
        idle(1);

        // R2 R3 R4 table walk
        foreach (VECS[k]) begin
            logic [7:0] lv, en, pat, ex;
            {lv, en, pat, ex} = VECS[k];
            port_in = ~lv;
            bwrite(2'd1, lv, 1'b0);
            bwrite(2'd2, en, 1'b0);
            rd_check("R2 level readback", 2'd1, lv);
            rd_check("R2 enable readback", 2'd2, en);
            bwrite(2'd0, 8'h00, 1'b0);
            port_in = pat;
            idle(1);
            port_in = ~lv;
            rd_check("R3 R4 vector flags", 2'd0, ex);
            bwrite(2'd0, 8'h00, 1'b0);
            rd_check("R5 vector clear", 2'd0, 8'h00);
        end

        // active-low, all enabled
        bwrite(2'd1, 8'h00, 1'b0);
        bwrite(2'd2, 8'hFF, 1'b0);
        port_in = 8'hFF;
        bwrite(2'd0, 8'h00, 1'b0);
        idle(2);

        // R6: event between read and write survives
        port_in = 8'hFB; idle(1); port_in = 8'hFF;
        rmw_read();
        port_in = 8'hDF; idle(2); port_in = 8'hFF;
        bwrite(2'd0, 8'h00, 1'b1);
        rd_check("R6 late event kept, early cleared", 2'd0, 8'h20);
        bwrite(2'd0, 8'h00, 1'b0);
        rd_check("R5 plain clear", 2'd0, 8'h00);

        // R6: event in the read cycle itself counts as late
        port_in = 8'hFD;
        rmw_read();
        port_in = 8'hFF;
        bwrite(2'd0, 8'h00, 1'b1);
        rd_check("R6 read-cycle event kept", 2'd0, 8'h02);
        bwrite(2'd0, 8'h00, 1'b0);

        // R7: event before read is cleared by write-back
        port_in = 8'hF7; idle(1); port_in = 8'hFF;
        idle(1);
        rmw_read();
        bwrite(2'd0, 8'h00, 1'b1);
        rd_check("R7 early event cleared", 2'd0, 8'h00);

        // R5: plain write after late event still clears
        port_in = 8'hBF; idle(1); port_in = 8'hFF;
        bwrite(2'd0, 8'h00, 1'b0);
        rd_check("R5 plain write clears", 2'd0, 8'h00);

        // R8: event in the same cycle as clearing write
        port_in = 8'hFE; idle(1); port_in = 8'hFF;
        port_in = 8'hFE;
        bwrite(2'd0, 8'h00, 1'b0);
        port_in = 8'hFF;
        rd_check("R8 same-cycle event wins", 2'd0, 8'h01);

        // R5: ones keep, zero clears
        bwrite(2'd0, 8'hFF, 1'b0);
        rd_check("R5 write ones keeps", 2'd0, 8'h01);
        bwrite(2'd0, 8'hFE, 1'b0);
        rd_check("R5 zero bit clears", 2'd0, 8'h00);
        idle(2);

        // R9: irq timing
        check("R9 irq idle", {7'd0, irq}, 8'h00);
        port_in = 8'hEF; idle(1); port_in = 8'hFF;
        rd_check("R3 single-cycle pulse captured", 2'd0, 8'h10);
        check("R9 irq lags flag", {7'd0, irq}, 8'h00);
        idle(1);
        check("R9 irq rises", {7'd0, irq}, 8'h01);
        bwrite(2'd2, 8'hEF, 1'b0);
        check("R9 irq still high at disable edge", {7'd0, irq}, 8'h01);
        idle(1);
        check("R9 irq falls after disable", {7'd0, irq}, 8'h00);
        bwrite(2'd2, 8'hFF, 1'b0);
        bwrite(2'd0, 8'h00, 1'b0);
        idle(2);

        // R10: held level keeps irq despite clears
        port_in = 8'h7F;
        idle(2);
        bwrite(2'd0, 8'h00, 1'b0);
        rd_check("R10 held flag resets", 2'd0, 8'h80);
        check("R10 irq held", {7'd0, irq}, 8'h01);
        idle(1);
        check("R10 irq still held", {7'd0, irq}, 8'h01);
        port_in = 8'hFF;
        bwrite(2'd0, 8'h00, 1'b0);
        idle(2);
        check("R10 irq released", {7'd0, irq}, 8'h00);

        // R4: disabled lines stay clear
        bwrite(2'd2, 8'h0F, 1'b0);
        port_in = 8'h00;
        idle(2);
        port_in = 8'hFF;
        rd_check("R4 disabled lines quiet", 2'd0, 8'h0F);
        bwrite(2'd0, 8'h00, 1'b0);

        // R11: unused select
        bwrite(2'd3, 8'hFF, 1'b0);
        rd_check("R11 unused reads zero", 2'd3, 8'h00);
        rd_check("R11 level untouched", 2'd1, 8'h00);
        rd_check("R11 enable untouched", 2'd2, 8'h0F);
        rd_check("R11 flags untouched", 2'd0, 8'h00);

        // R1: reset mid-run
        port_in = 8'hF0; idle(1); port_in = 8'hFF;
        rst = 1'b1; idle(1); rst = 1'b0;
        rd_check("R1 flags after reset", 2'd0, 8'h00);
        rd_check("R1 enable after reset", 2'd2, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule